// File: doc/BRIEF.md
# Command-Fetching I/O Channel Engine

This block is a small I/O processor that works for a host. The host is the master. It hands over the address of a command program and a one-cycle go strobe. From then on the engine runs on its own. It fetches 32-bit command words in sequence over a single-word memory port and executes each one. While this happens the host is free to do other work, and it can read a live status view at any time.

A program is built from four kinds of command:
- **Block move.** Copies a run of words from memory to an outgoing device FIFO, or from an incoming device FIFO into memory.
- **ALU set-up.** Arms an arithmetic or logic operation. That operation is applied to every word of the next block move only.
- **Control.** Fires a one-cycle pulse on one of eight device control lines.
- **End.** Closes the program.

When the program ends, the engine writes a status word to a fixed memory location and raises a done flag. It does the same when it meets a malformed command, and in that case it also sets an error bit.

The memory port has a fixed latency of one cycle. A read issued in cycle t returns its data in cycle t+1. A write completes in the cycle it is issued.

Top module: `ioch_engine`

## Requirements
- R1: After reset, `host_busy`, `host_done`, `host_status`, `dev_ctl`, `mem_req`, `dev_out_push` and `dev_in_pop` are all zero. While idle, the engine issues no memory or device traffic.
- R2: A `host_go` pulse while idle does the following:
  - it latches `host_prog` as the program counter;
  - it clears done, error and the command count;
  - it raises `host_busy`.
  Command words are then fetched from consecutive addresses.
- R3: Bits [31:30] of a command select its class: 0 block, 1 ALU, 2 control, 3 end. A block command with bit 29 = 1 moves [11:0] words from the device input FIFO into memory. The word after the command gives the first memory address, and the following words go to consecutive addresses. A word is taken only when `dev_in_valid` is high.
- R4: A block command with bit 29 = 0 reads [11:0] words from consecutive memory addresses, starting at the address word. It pushes them to the device output in memory order, and never pushes while `dev_out_full` is high.
- R5: An ALU command (class 1) selects an operation in bits [17:16]: 0 ADD (mod 2^32), 1 AND, 2 OR, 3 XOR. The operand is bits [15:0], zero-extended to 32 bits. The operation applies to every word of the next block move only. Later moves pass data unchanged.
- R6: A control command (class 2) drives `dev_ctl` bit [2:0] high for exactly one cycle. At most one `dev_ctl` bit is ever high.
- R7: On an end command, the engine writes the status word to address `STATUS_ADDR`. The status word has bit 31 = 1, bit 30 = error, bits [29:16] = 0, and bits [15:0] = the number of block, ALU and control commands executed. In the next cycle `host_done` is 1 and `host_busy` is 0. `host_status` then shows the same word.
- R8: A command is illegal if any of its reserved bits is set: [28:12] for a block command, [29:18] for an ALU command, [29:3] for a control command. An illegal command stops the program without any effect of its own. The status word is then written with the error bit set, and the illegal command is not counted.
- R9: A `host_go` pulse while busy is ignored. The running program's results and status are unchanged.
- R10: A block command with a count of 0 moves no word. It still consumes its address word, counts as executed, and uses up a pending ALU set-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_go | input | 1 | Start strobe from the host |
| host_prog | input | ADDR_W | Address of the first command word |
| host_busy | output | 1 | Program running |
| host_done | output | 1 | Last program finished |
| host_status | output | 32 | Live status: done, error, command count |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| dev_in_valid | input | 1 | Device input FIFO has a word |
| dev_in_data | input | 32 | Device input word |
| dev_in_pop | output | 1 | Takes the current device input word |
| dev_out_full | input | 1 | Device output FIFO cannot accept a word |
| dev_out_push | output | 1 | Pushes `dev_out_data` |
| dev_out_data | output | 32 | Device output word |
| dev_ctl | output | 8 | One-cycle device control pulses |

## Verification
Two host-visible events can fall in the same cycle, and both are provoked deliberately.

The first is a new go strobe that arrives while a program is still running. The bench pulses `host_go` a few cycles after the start. It points that strobe at a region filled with random words, which would decode into a different program. The run is judged by requiring the memory image, the device output stream and the status word to match what the first program alone produces.

The second is the final status write together with the last data movement. Random programs often end with a block move, so the status write follows the last FIFO word directly. The bench checks that `host_done` and the word stored at `STATUS_ADDR` agree with a model count.

// File: rtl/ioch_pkg.sv
// Shared types and command field constants for the I/O channel engine.
// Assumes 32-bit command and data words.
package ioch_pkg;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 12;
    localparam int IMM_W   = 16;
    localparam int CTL_N   = 8;
    localparam int SEL_W   = $clog2(CTL_N);

    localparam logic [1:0] CLS_BLK = 2'd0;
    localparam logic [1:0] CLS_ALU = 2'd1;
    localparam logic [1:0] CLS_CTL = 2'd2;
    localparam logic [1:0] CLS_END = 2'd3;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } ioch_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_DECODE, S_AFETCH, S_ALOAD,
        S_MRD, S_MLAT, S_MPUSH, S_DIN, S_STAT
    } ioch_state_e;
endpackage

// File: rtl/ioch_decode.sv
// Splits a command word into its fields and flags reserved bits that are set.
// Assumes the word is the one returned for the last fetch.
module ioch_decode
    import ioch_pkg::*;
(
    input  logic [WORD_W-1:0] cmd,
    output logic [1:0]        cls,
    output logic              dir_in,
    output logic [LEN_W-1:0]  len,
    output ioch_op_e          op,
    output logic [IMM_W-1:0]  imm,
    output logic [SEL_W-1:0]  sel,
    output logic              bad
);
    assign cls    = cmd[31:30];
    assign dir_in = cmd[29];
    assign len    = cmd[LEN_W-1:0];
    assign op     = ioch_op_e'(cmd[17:16]);
    assign imm    = cmd[IMM_W-1:0];
    assign sel    = cmd[SEL_W-1:0];

    // Reserved-bit check per command class
    always_comb begin
        unique case (cls)
            CLS_BLK: bad = |cmd[28:LEN_W];
            CLS_ALU: bad = |cmd[29:18];
            CLS_CTL: bad = |cmd[29:SEL_W];
            default: bad = 1'b0;
        endcase
    end
endmodule

// File: rtl/ioch_alu.sv
// Applies the armed operation to a word in flight; passes it through when disarmed.
// Assumes the immediate is zero-extended.
module ioch_alu
    import ioch_pkg::*;
(
    input  logic              en,
    input  ioch_op_e          op,
    input  logic [IMM_W-1:0]  imm,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] opnd;
    assign opnd = {{(WORD_W-IMM_W){1'b0}}, imm};

    // Select the result of the chosen operation
    always_comb begin
        if (!en) dout = din;
        else begin
            unique case (op)
                OP_ADD: dout = din + opnd;
                OP_AND: dout = din & opnd;
                OP_OR:  dout = din | opnd;
                default: dout = din ^ opnd;
            endcase
        end
    end
endmodule

// File: rtl/ioch_engine.sv
// Command-fetching I/O channel engine. Fetches commands from memory after a host
// go strobe, moves blocks between memory and device FIFOs, applies an armed ALU
// operation, pulses control lines, then writes a status word and flags done.
// Assumes a one-cycle read latency and no other memory master.
module ioch_engine
    import ioch_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          CNT_W       = 16,
    parameter logic [15:0] STATUS_ADDR = 16'h00FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_go,
    input  logic [ADDR_W-1:0] host_prog,
    output logic              host_busy,
    output logic              host_done,
    output logic [31:0]       host_status,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_pop,
    input  logic              dev_out_full,
    output logic              dev_out_push,
    output logic [31:0]       dev_out_data,
    output logic [7:0]        dev_ctl
);
    localparam int PAD_W = WORD_W - 2 - CNT_W;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    ioch_state_e       state;
    logic [ADDR_W-1:0] pc, ptr;
    logic [LEN_W-1:0]  remain;
    logic              dir_q, aen, err, done;
    ioch_op_e          aop;
    logic [IMM_W-1:0]  aimm;
    logic [CNT_W-1:0]  cmd_cnt;
    logic [WORD_W-1:0] data_q, alu_out;
    logic [CTL_N-1:0]  ctl_hit, ctl_q;

    logic [1:0]       d_cls;
    logic             d_dir, d_bad;
    logic [LEN_W-1:0] d_len;
    ioch_op_e         d_op;
    logic [IMM_W-1:0] d_imm;
    logic [SEL_W-1:0] d_sel;

    ioch_decode u_dec (
        .cmd(mem_rdata), .cls(d_cls), .dir_in(d_dir), .len(d_len),
        .op(d_op), .imm(d_imm), .sel(d_sel), .bad(d_bad)
    );

    ioch_alu u_alu (
        .en(aen), .op(aop), .imm(aimm),
        .din(dir_q ? dev_in_data : mem_rdata), .dout(alu_out)
    );

    // One-hot decode of the control line to pulse
    for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
        assign ctl_hit[i] = (state == S_DECODE) && (d_cls == CLS_CTL) &&
                            !d_bad && (d_sel == SEL_W'(i));
    end

    assign host_busy    = (state != S_IDLE);
    assign host_done    = done;
    assign host_status  = {done, err, {PAD_W{1'b0}}, cmd_cnt};
    assign dev_ctl      = ctl_q;
    assign dev_out_data = data_q;
    assign dev_out_push = (state == S_MPUSH) && !dev_out_full;
    assign dev_in_pop   = (state == S_DIN) && dev_in_valid;

    // Memory port request, address and write data per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc;
        mem_wdata = alu_out;
        unique case (state)
            S_FETCH, S_AFETCH: mem_req = 1'b1;
            S_MRD: begin mem_req = 1'b1; mem_addr = ptr; end
            S_DIN: begin mem_req = dev_in_valid; mem_we = dev_in_valid; mem_addr = ptr; end
            S_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = STAT_A;
                mem_wdata = {1'b1, err, {PAD_W{1'b0}}, cmd_cnt};
            end
            default: ;
        endcase
    end

    // Sequencer: fetch, decode and execute commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pc      <= '0;
            ptr     <= '0;
            remain  <= '0;
            dir_q   <= 1'b0;
            aen     <= 1'b0;
            aop     <= OP_ADD;
            aimm    <= '0;
            err     <= 1'b0;
            done    <= 1'b0;
            cmd_cnt <= '0;
            data_q  <= '0;
            ctl_q   <= '0;
        end else begin
            ctl_q <= ctl_hit;
            unique case (state)
                S_IDLE: if (host_go) begin
                    pc      <= host_prog;
                    cmd_cnt <= '0;
                    err     <= 1'b0;
                    done    <= 1'b0;
                    aen     <= 1'b0;
                    state   <= S_FETCH;
                end
                S_FETCH: begin
                    pc    <= pc + 1'b1;
                    state <= S_DECODE;
                end
                S_DECODE: begin
                    if (d_bad) begin
                        err   <= 1'b1;
                        state <= S_STAT;
                    end else begin
                        unique case (d_cls)
                            CLS_BLK: begin
                                dir_q  <= d_dir;
                                remain <= d_len;
                                state  <= S_AFETCH;
                            end
                            CLS_ALU: begin
                                aen     <= 1'b1;
                                aop     <= d_op;
                                aimm    <= d_imm;
                                cmd_cnt <= cmd_cnt + 1'b1;
                                state   <= S_FETCH;
                            end
                            CLS_CTL: begin
                                cmd_cnt <= cmd_cnt + 1'b1;
                                state   <= S_FETCH;
                            end
                            default: state <= S_STAT;
                        endcase
                    end
                end
                S_AFETCH: begin
                    pc    <= pc + 1'b1;
                    state <= S_ALOAD;
                end
                S_ALOAD: begin
                    ptr <= mem_rdata[ADDR_W-1:0];
                    if (remain == '0) begin
                        cmd_cnt <= cmd_cnt + 1'b1;
                        aen     <= 1'b0;
                        state   <= S_FETCH;
                    end else begin
                        state <= dir_q ? S_DIN : S_MRD;
                    end
                end
                S_MRD: state <= S_MLAT;
                S_MLAT: begin
                    data_q <= alu_out;
                    state  <= S_MPUSH;
                end
                S_MPUSH, S_DIN: if ((state == S_MPUSH) ? !dev_out_full : dev_in_valid) begin
                    ptr    <= ptr + 1'b1;
                    remain <= remain - 1'b1;
                    if (remain == LEN_W'(1)) begin
                        cmd_cnt <= cmd_cnt + 1'b1;
                        aen     <= 1'b0;
                        state   <= S_FETCH;
                    end else begin
                        state <= (state == S_MPUSH) ? S_MRD : S_DIN;
                    end
                end
                S_STAT: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ioch_engine_chk.sv
// Protocol checker for ioch_engine, attached by bind. Observes ports only.
module ioch_engine_chk #(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] STATUS_ADDR = 16'h00FC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_busy,
    input logic              host_done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dev_in_pop,
    input logic              dev_in_valid,
    input logic              dev_out_push,
    input logic              dev_out_full,
    input logic [7:0]        dev_ctl
);
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> (!mem_req && !dev_out_push && !dev_in_pop && !mem_we));

    a_r3_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dev_in_pop |-> dev_in_valid);

    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_push |-> !dev_out_full);

    a_r6_ctl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ctl));

    a_r6_ctl_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ctl != 8'h00) |=> (dev_ctl == 8'h00));

    a_r7_done_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_done) |-> $past(mem_we && (mem_addr == ADDR_W'(STATUS_ADDR))));

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !host_busy);
endmodule

bind ioch_engine ioch_engine_chk #(.ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)) u_chk (.*);

// File: tb/ioch_engine_tb.sv
// Self-checking bench: directed and seeded random command programs,
// compared against a bench model of the command set.
module ioch_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int SA = 8'hFC;
    localparam int PBASE = 8'h10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_go = 1'b0;
    logic [AW-1:0] host_prog = '0;
    logic host_busy, host_done, mem_req, mem_we, dev_in_pop, dev_out_push;
    logic [31:0] host_status, mem_wdata, dev_out_data;
    logic [31:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic dev_in_valid = 1'b0, dev_out_full = 1'b0;
    logic [31:0] dev_in_data;
    logic [7:0] dev_ctl;

    ioch_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_go(host_go), .host_prog(host_prog),
        .host_busy(host_busy), .host_done(host_done), .host_status(host_status),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_pop(dev_in_pop),
        .dev_out_full(dev_out_full), .dev_out_push(dev_out_push),
        .dev_out_data(dev_out_data), .dev_ctl(dev_ctl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] mem [256];
    logic [31:0] exp_mem [256];
    logic [31:0] in_words [64];
    logic [31:0] out_got [64];
    logic [31:0] out_exp [64];
    logic [31:0] prog [32];
    int in_idx, out_n, plen, n_chk, n_bad;
    int ctl_got [8];

    assign dev_in_data = in_words[in_idx % 64];

    // Memory model with one-cycle read latency; device FIFO bookkeeping
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
        if (dev_in_pop) in_idx <= in_idx + 1;
        if (dev_out_push) begin
            if (out_n < 64) out_got[out_n] <= dev_out_data;
            out_n <= out_n + 1;
        end
        for (int i = 0; i < 8; i++) if (dev_ctl[i]) ctl_got[i] <= ctl_got[i] + 1;
    end

    // Random FIFO flow control, changed away from the active edge
    always @(negedge clk) begin
        dev_in_valid <= (in_idx < 64) && ($urandom % 4 != 0);
        dev_out_full <= ($urandom % 4 == 0);
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] f_blk(input bit din, input int n);
        return {2'd0, din, 17'd0, 12'(n)};
    endfunction
    function automatic logic [31:0] f_alu(input int op, input int imm);
        return {2'd1, 12'd0, 2'(op), 16'(imm)};
    endfunction
    function automatic logic [31:0] f_ctl(input int sel);
        return {2'd2, 27'd0, 3'(sel)};
    endfunction
    function automatic logic [31:0] f_apply(input bit en, input logic [1:0] op,
                                            input logic [15:0] imm, input logic [31:0] d);
        logic [31:0] x;
        x = {16'd0, imm};
        if (!en) return d;
        case (op)
            2'd0: return d + x;
            2'd1: return d & x;
            2'd2: return d | x;
            default: return d ^ x;
        endcase
    endfunction

    task automatic put(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // Run the program in prog[] from PBASE; optionally strobe go while busy (R9)
    task automatic run(input string tag, input bit busy_go);
        int pc, cnt, on, ii, n, a, cyc;
        bit err, fin, aen;
        logic [1:0] aop;
        logic [15:0] aimm;
        logic [31:0] w, st;
        int ectl [8];
        for (int i = 0; i < 256; i++) mem[i] = $urandom;
        mem[SA] = 32'h0;
        for (int i = 0; i < plen; i++) mem[PBASE + i] = prog[i];
        for (int i = 0; i < 256; i++) exp_mem[i] = mem[i];
        for (int i = 0; i < 64; i++) in_words[i] = $urandom;
        for (int i = 0; i < 8; i++) begin ctl_got[i] = 0; ectl[i] = 0; end
        in_idx = 0; out_n = 0;
        pc = PBASE; cnt = 0; on = 0; ii = 0; err = 0; fin = 0; aen = 0; aop = 0; aimm = 0;
        while (!fin) begin
            w = exp_mem[pc % 256]; pc++;
            case (w[31:30])
                2'd0: if (|w[28:12]) begin err = 1; fin = 1; end else begin
                    n = int'(w[11:0]); a = int'(exp_mem[pc % 256][7:0]); pc++;
                    for (int k = 0; k < n; k++) begin
                        if (w[29]) begin exp_mem[(a + k) % 256] = f_apply(aen, aop, aimm, in_words[ii]); ii++; end
                        else begin out_exp[on] = f_apply(aen, aop, aimm, exp_mem[(a + k) % 256]); on++; end
                    end
                    cnt++; aen = 0;
                end
                2'd1: if (|w[29:18]) begin err = 1; fin = 1; end else begin
                    aen = 1; aop = w[17:16]; aimm = w[15:0]; cnt++;
                end
                2'd2: if (|w[29:3]) begin err = 1; fin = 1; end else begin
                    ectl[w[2:0]]++; cnt++;
                end
                default: fin = 1;
            endcase
        end
        st = {1'b1, err, 14'd0, 16'(cnt)};
        exp_mem[SA] = st;
        @(negedge clk); host_prog = AW'(PBASE); host_go = 1'b1;
        @(negedge clk); host_go = 1'b0;
        if (busy_go) begin
            repeat (4) @(negedge clk);
            host_prog = 16'h0040; host_go = 1'b1;
            @(negedge clk); host_go = 1'b0;
        end
        cyc = 0;
        while (!host_done) begin
            @(negedge clk); cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL %s watchdog: actual busy expected done", tag);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
        @(negedge clk);
        chk(tag, "R7 host_done", 32'(host_done), 32'd1);
        chk(tag, "R7 host_busy", 32'(host_busy), 32'd0);
        chk(tag, "R7/R8 host_status", host_status, st);
        for (int i = 0; i < 256; i++)
            if (mem[i] !== exp_mem[i]) chk(tag, $sformatf("R3/R7 mem[%0h]", i), mem[i], exp_mem[i]);
        n_chk++;
        chk(tag, "R4 push count", 32'(out_n), 32'(on));
        for (int i = 0; i < on && i < 64; i++) chk(tag, $sformatf("R4/R5 out[%0d]", i), out_got[i], out_exp[i]);
        chk(tag, "R3 pop count", 32'(in_idx), 32'(ii));
        for (int i = 0; i < 8; i++) chk(tag, $sformatf("R6 ctl[%0d] pulses", i), 32'(ctl_got[i]), 32'(ectl[i]));
    endtask

    initial begin
        void'($urandom(32'd1234));
        n_chk = 0; n_bad = 0; in_idx = 0; out_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy", 32'(host_busy), 0);
        chk("R1", "done", 32'(host_done), 0);
        chk("R1", "status", host_status, 0);
        chk("R1", "ctl", 32'(dev_ctl), 0);
        chk("R1", "mem_req", 32'(mem_req), 0);
        chk("R1", "push/pop", 32'({dev_out_push, dev_in_pop}), 0);

        // R2 R4 R5 R3 R6: ALU add then memory-to-device, control, plain device-to-memory
        plen = 0;
        put(f_alu(0, 16'hFFFF)); put(f_blk(0, 3)); put(32'h80);
        put(f_ctl(5)); put(f_blk(1, 4)); put(32'hC0); put(32'hC000_0000);
        run("R2/R5 add", 0);

        // R10 zero count consumes the ALU set-up; R5 XOR; R6 line 7
        plen = 0;
        put(f_alu(3, 16'h5A5A)); put(f_blk(1, 0)); put(32'hC8);
        put(f_blk(1, 2)); put(32'hD0); put(f_alu(1, 16'h00F0)); put(f_blk(0, 2)); put(32'hD0);
        put(f_ctl(7)); put(32'hC000_0000);
        run("R10 zero", 0);

        // R8 illegal ALU command stops the program, not counted
        plen = 0;
        put(f_ctl(1)); put(f_alu(2, 16'h1) | 32'h0010_0000); put(f_ctl(2)); put(32'hC000_0000);
        run("R8 illegal", 0);

        // R9 go while busy is ignored
        plen = 0;
        put(f_alu(2, 16'h8001)); put(f_blk(1, 6)); put(32'hE0);
        put(f_blk(0, 6)); put(32'hE0); put(f_ctl(0)); put(32'hC000_0000);
        run("R9 go busy", 1);

        // Seeded random programs
        for (int r = 0; r < 10; r++) begin
            int n;
            plen = 0;
            n = 1 + $urandom % 6;
            for (int c = 0; c < n; c++) begin
                case ($urandom % 3)
                    0: begin
                        if ($urandom % 2) begin put(f_blk(1, $urandom % 6)); put(32'hC0 + $urandom % 32); end
                        else begin put(f_blk(0, $urandom % 6)); put(32'h80 + $urandom % 32); end
                    end
                    1: put(f_alu($urandom % 4, $urandom % 65536));
                    default: put(f_ctl($urandom % 8));
                endcase
            end
            put(32'hC000_0000);
            run($sformatf("R3/R4 rand%0d", r), (r % 3) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule